// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

This block moves a programmed number of words between one peripheral and memory while the processor is off the bus. The processor first programs a start address, a word count and a control word through a small register port. Access to that port needs the chip-select input, and a two-bit selector chooses the register. Once the block is enabled, every request from the peripheral makes the engine ask for the system bus. It waits for the grant, then runs a single memory cycle. In that cycle it drives the address and a read or write strobe and acknowledges the peripheral. It then steps the address and the remaining count.

The read and write strobes share pins with the processor's register-access strobes. While the grant is low, those pins are inputs and the register port is live. While the grant is high, the engine is bus master and drives them. The pin sharing is modelled with separate input and output signals plus output-enable signals. When the count reaches zero, the engine releases the bus, disables itself and raises a single-cycle interrupt, so the processor is interrupted once per block.

Top module: `dma_ctl`

## Requirements
- R1: After reset the bus request, interrupt, acknowledge, both memory strobes and both output enables are low, and the status register reads 4.
- R2: With cs_i high and bus_gnt_i low, a cycle with cpu_wr_i high writes the register chosen by reg_sel_i. The codes are: 0 address, 1 word count, 2 control (bit 0 enable, bit 1 direction), 3 status (read only). With cpu_rd_i also high, cpu_rdata_o returns that register in the same cycle. Status holds bit 0 enable, bit 1 bus request and bit 2 count-is-zero. cpu_rdata_o is 0 whenever cs_i, cpu_rd_i or a low bus_gnt_i is missing.
- R3: A register write strobe has no effect when cs_i is low or when bus_gnt_i is high.
- R4: A peripheral request while the block is enabled and the count is non-zero raises bus_req_o. No memory strobe is issued until bus_gnt_i is high.
- R5: Each transfer is one cycle with dev_ack_o high and mem_addr_o equal to the current address. With direction 0 (peripheral to memory), mem_wr_o is high and mem_wdata_o carries dev_wdata_i. With direction 1 (memory to peripheral), mem_rd_o is high and dev_rdata_o carries mem_rdata_i. The two strobes are never high together.
- R6: After each transfer the address is one higher (wrapping at its width) and the count is one lower.
- R7: After the transfer that brings the count to zero, bus_req_o drops, enable clears and irq_o is high for exactly one cycle.
- R8: In the cycle after an acknowledge, a low peripheral request releases bus_req_o. A high request keeps the bus and starts the next transfer.
- R9: mem_addr_oe_o and mem_strb_oe_o equal bus_gnt_i, and both strobes are low whenever bus_gnt_i is low.
- R10: No bus request is made while the block is disabled or the count is zero, even with a peripheral request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select for the register port |
| reg_sel_i | input | 2 | Register selector |
| cpu_rd_i | input | 1 | Register read strobe (shared pin, input side) |
| cpu_wr_i | input | 1 | Register write strobe (shared pin, input side) |
| cpu_wdata_i | input | DW | Register write data |
| cpu_rdata_o | output | DW | Register read data |
| bus_req_o | output | 1 | System bus request |
| bus_gnt_i | input | 1 | System bus grant |
| dev_req_i | input | 1 | Peripheral transfer request |
| dev_ack_o | output | 1 | Peripheral acknowledge, one cycle per word |
| dev_wdata_i | input | DW | Word from peripheral |
| dev_rdata_o | output | DW | Word to peripheral |
| mem_addr_o | output | AW | Memory address |
| mem_addr_oe_o | output | 1 | Address output enable |
| mem_rd_o | output | 1 | Memory read strobe (shared pin, output side) |
| mem_wr_o | output | 1 | Memory write strobe (shared pin, output side) |
| mem_strb_oe_o | output | 1 | Strobe output enable |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data |
| irq_o | output | 1 | End-of-block interrupt pulse |

## Verification
The hardest case to reach from the ports is deciding between keeping the bus and releasing it. That decision hangs on the peripheral request in the single cycle after an acknowledge, and it interacts with how late the grant comes back. The bench models the peripheral with a configurable hold-off after each acknowledge and the arbiter with a configurable grant delay. It sweeps direction, word count, hold-off and grant delay, and counts bus-request rising edges to tell a held bus from one released between words. An address near the top of the range is used to force the address wrap, and the peripheral offers one extra word past the block end to show the disabled engine stays off the bus.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2,
    ST_GAP  = 2'd3
  } dma_state_e;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  localparam int CTRL_EN  = 0;
  localparam int CTRL_DIR = 1;
  localparam int STAT_EN   = 0;
  localparam int STAT_REQ  = 1;
  localparam int STAT_ZERO = 2;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_ctl_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic [1:0]    reg_sel_i,
  input  logic          cpu_rd_i,
  input  logic          cpu_wr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  input  logic          bus_gnt_i,
  input  logic          bus_req_i,
  input  logic          step_i,
  input  logic          done_i,
  output logic [AW-1:0] addr_o,
  output logic          en_o,
  output logic          dir_o,
  output logic          cnt_zero_o,
  output logic          cnt_last_o
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic          en_q, dir_q;
  logic          port_live, wr_hit;

  assign port_live = cs_i && !bus_gnt_i;
  assign wr_hit    = port_live && cpu_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
      en_q   <= 1'b0;
      dir_q  <= 1'b0;
    end else begin
      if (step_i) begin
        addr_q <= addr_q + 1'b1;
        cnt_q  <= cnt_q - 1'b1;
      end else if (wr_hit) begin
        case (reg_sel_i)
          SEL_ADDR: addr_q <= cpu_wdata_i[AW-1:0];
          SEL_CNT:  cnt_q  <= cpu_wdata_i[CW-1:0];
          SEL_CTRL: begin
            en_q  <= cpu_wdata_i[CTRL_EN];
            dir_q <= cpu_wdata_i[CTRL_DIR];
          end
          default: ;
        endcase
      end
      if (done_i) en_q <= 1'b0;
    end
  end

  always_comb begin
    cpu_rdata_o = '0;
    if (port_live && cpu_rd_i) begin
      case (reg_sel_i)
        SEL_ADDR: cpu_rdata_o = DW'(addr_q);
        SEL_CNT:  cpu_rdata_o = DW'(cnt_q);
        SEL_CTRL: cpu_rdata_o = DW'({dir_q, en_q});
        default: begin
          cpu_rdata_o[STAT_EN]   = en_q;
          cpu_rdata_o[STAT_REQ]  = bus_req_i;
          cpu_rdata_o[STAT_ZERO] = (cnt_q == '0);
        end
      endcase
    end
  end

  assign addr_o     = addr_q;
  assign en_o       = en_q;
  assign dir_o      = dir_q;
  assign cnt_zero_o = (cnt_q == '0);
  assign cnt_last_o = (cnt_q == CNT_ONE);

  AST_STEP_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (cnt_q == $past(cnt_q) - 1'b1) && (addr_q == $past(addr_q) + 1'b1)); // R6

  AST_PORT_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && (!cs_i || bus_gnt_i) && !step_i && !done_i)
      |=> $stable(addr_q) && $stable(cnt_q) && $stable(en_q) && $stable(dir_q)); // R3
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_ctl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic cnt_zero_i,
  input  logic cnt_last_i,
  input  logic dev_req_i,
  input  logic bus_gnt_i,
  output logic bus_req_o,
  output logic step_o,
  output logic done_o,
  output logic irq_o
);
  dma_state_e state_q, state_d;
  logic       irq_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (en_i && !cnt_zero_i && dev_req_i) state_d = ST_REQ;
      ST_REQ: begin
        if (!en_i)          state_d = ST_IDLE;
        else if (bus_gnt_i) state_d = ST_XFER;
      end
      ST_XFER: state_d = cnt_last_i ? ST_IDLE : ST_GAP;
      ST_GAP: begin
        if (!dev_req_i)     state_d = ST_IDLE;
        else if (bus_gnt_i) state_d = ST_XFER;
        else                state_d = ST_REQ;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= done_o;
    end
  end

  assign step_o    = (state_q == ST_XFER);
  assign done_o    = step_o && cnt_last_i;
  assign bus_req_o = (state_q != ST_IDLE);
  assign irq_o     = irq_q;

  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R7

  AST_IRQ_BUS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !bus_req_o && !en_i); // R7

  AST_NO_REQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_req_o && (!en_i || cnt_zero_i)) |=> !bus_req_o); // R10

  AST_XFER_GRANTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_gnt_i) |=> !step_o); // R4
endmodule

// File: rtl/dma_port.sv
module dma_port #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          bus_gnt_i,
  input  logic          step_i,
  input  logic          dir_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] dev_wdata_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] dev_rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_addr_oe_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic          mem_strb_oe_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          dev_ack_o
);
  logic own_bus;
  assign own_bus = bus_gnt_i;

  assign mem_addr_oe_o = own_bus;
  assign mem_strb_oe_o = own_bus;
  assign mem_addr_o    = addr_i;
  assign mem_rd_o      = own_bus && step_i &&  dir_i;
  assign mem_wr_o      = own_bus && step_i && !dir_i;
  assign mem_wdata_o   = dev_wdata_i;
  assign dev_rdata_o   = mem_rdata_i;
  assign dev_ack_o     = step_i;

  always_comb begin
    AST_STRB_EXCL: assert (!(mem_rd_o && mem_wr_o)); // R5
    AST_STRB_NEEDS_GNT: assert (!(mem_rd_o || mem_wr_o) || mem_strb_oe_o); // R9
    AST_ACK_HAS_STRB: assert (!dev_ack_o || !bus_gnt_i || mem_rd_o || mem_wr_o); // R5
  end
endmodule

// File: rtl/dma_ctl.sv
module dma_ctl
  import dma_ctl_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic [1:0]    reg_sel_i,
  input  logic          cpu_rd_i,
  input  logic          cpu_wr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  input  logic          dev_req_i,
  output logic          dev_ack_o,
  input  logic [DW-1:0] dev_wdata_i,
  output logic [DW-1:0] dev_rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_addr_oe_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic          mem_strb_oe_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          irq_o
);
  logic [AW-1:0] addr;
  logic en, dir, cnt_zero, cnt_last, step, done;

  dma_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
    .clk_i, .rst_ni, .cs_i, .reg_sel_i, .cpu_rd_i, .cpu_wr_i,
    .cpu_wdata_i, .cpu_rdata_o, .bus_gnt_i,
    .bus_req_i  (bus_req_o),
    .step_i     (step),
    .done_i     (done),
    .addr_o     (addr),
    .en_o       (en),
    .dir_o      (dir),
    .cnt_zero_o (cnt_zero),
    .cnt_last_o (cnt_last)
  );

  dma_seq u_seq (
    .clk_i, .rst_ni,
    .en_i       (en),
    .cnt_zero_i (cnt_zero),
    .cnt_last_i (cnt_last),
    .dev_req_i, .bus_gnt_i, .bus_req_o,
    .step_o     (step),
    .done_o     (done),
    .irq_o
  );

  dma_port #(.AW(AW), .DW(DW)) u_port (
    .bus_gnt_i,
    .step_i  (step),
    .dir_i   (dir),
    .addr_i  (addr),
    .dev_wdata_i, .mem_rdata_i, .dev_rdata_o, .mem_addr_o, .mem_addr_oe_o,
    .mem_rd_o, .mem_wr_o, .mem_strb_oe_o, .mem_wdata_o, .dev_ack_o
  );
endmodule

// File: tb/dma_ctl_tb_top.sv
`timescale 1ns/1ps
module dma_ctl_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cs, rd, wr, bus_req, gnt_q, force_gnt, bus_gnt, dev_req, dev_ack;
  logic mem_addr_oe, mem_rd, mem_wr, mem_strb_oe, irq;
  logic [1:0] sel;
  logic [7:0] wdata, rdata, dev_wdata, dev_rdata, mem_addr, mem_wdata, mem_rdata;
  logic [7:0] mem [256];

  int checks = 0, errors = 0;
  int pending = 0, hold = 0, gap_cfg = 0, gd_cfg = 0, dly = 0;
  int k = 0, rises = 0, irqs = 0;
  logic [7:0] exp_start;
  logic exp_dir, prev_req, prev_irq;
  bit done_all = 0;

  assign bus_gnt   = gnt_q | force_gnt;
  assign dev_req   = (pending != 0) && (hold == 0);
  assign mem_rdata = mem[mem_addr];
  assign dev_wdata = 8'hA0 + 8'(k);

  dma_ctl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .reg_sel_i(sel), .cpu_rd_i(rd),
    .cpu_wr_i(wr), .cpu_wdata_i(wdata), .cpu_rdata_o(rdata), .bus_req_o(bus_req),
    .bus_gnt_i(bus_gnt), .dev_req_i(dev_req), .dev_ack_o(dev_ack),
    .dev_wdata_i(dev_wdata), .dev_rdata_o(dev_rdata), .mem_addr_o(mem_addr),
    .mem_addr_oe_o(mem_addr_oe), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_strb_oe_o(mem_strb_oe), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // arbiter: grant after gd_cfg extra cycles, drops one edge after request
  always_ff @(posedge clk) begin
    if (!bus_req) begin gnt_q <= 1'b0; dly <= 0; end
    else if (dly >= gd_cfg) gnt_q <= 1'b1;
    else dly <= dly + 1;
  end

  // peripheral: word count and hold-off after each acknowledge
  always_ff @(posedge clk) begin
    if (dev_ack) begin
      pending <= pending - 1;
      hold    <= gap_cfg;
      k       <= k + 1;
    end else if (hold > 0) hold <= hold - 1;
  end

  // bus monitor
  always @(negedge clk) begin
    if (rst_n) begin
      chk(mem_addr_oe == bus_gnt && mem_strb_oe == bus_gnt, "R9 oe", mem_addr_oe, bus_gnt);
      if (!bus_gnt) chk(!mem_rd && !mem_wr, "R9 strobe without grant", mem_rd, 0);
      if (dev_ack || mem_rd || mem_wr) begin
        chk(dev_ack, "R5 ack", dev_ack, 1);
        chk(mem_addr == exp_start + 8'(k), "R6 address", mem_addr, exp_start + 8'(k));
        chk(mem_rd == exp_dir && mem_wr == !exp_dir, "R5 strobe select", {mem_rd, mem_wr}, {exp_dir, !exp_dir});
        if (exp_dir) chk(dev_rdata == (mem_addr ^ 8'h5A), "R5 mem to dev data", dev_rdata, mem_addr ^ 8'h5A);
        else begin
          chk(mem_wdata == 8'hA0 + 8'(k), "R5 dev to mem data", mem_wdata, 8'hA0 + 8'(k));
          mem[mem_addr] = mem_wdata;
        end
      end
      if (bus_req && !prev_req) rises++;
      if (irq) begin
        irqs++;
        chk(!prev_irq, "R7 irq width", 2, 1);
        chk(!bus_req, "R7 request released at irq", bus_req, 0);
      end
      prev_req = bus_req;
      prev_irq = irq;
    end
  end

  task automatic reg_wr(input logic [1:0] s, input logic [7:0] d, input logic c = 1'b1);
    @(negedge clk); cs = c; sel = s; wr = 1'b1; wdata = d;
    @(negedge clk); cs = 1'b0; wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); cs = 1'b1; sel = s; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); cs = 1'b0; rd = 1'b0;
  endtask

  task automatic run_job(input logic dir, input int n, input int gd, input int gp, input logic [7:0] st);
    logic [7:0] v;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    gd_cfg = gd; gap_cfg = gp; exp_start = st; exp_dir = dir;
    @(negedge clk); k = 0; rises = 0; irqs = 0;
    reg_wr(2'd0, st);
    reg_wr(2'd1, 8'(n));
    reg_wr(2'd2, {6'd0, dir, 1'b1});
    @(negedge clk); pending = n + 1;
    for (int t = 0; t < 400 && irqs == 0; t++) @(negedge clk);
    chk(irqs == 1, "R7 interrupt seen", irqs, 1);
    repeat (6) @(negedge clk);
    chk(!bus_req, "R10 extra request after block", bus_req, 0);
    chk(irqs == 1, "R7 single interrupt", irqs, 1);
    chk(k == n, "R6 word count", k, n);
    chk(rises == ((gp > 0) ? n : 1), "R8 request rises", rises, (gp > 0) ? n : 1);
    pending = 0;
    repeat (2) @(negedge clk);
    reg_rd(2'd0, v); chk(v == st + 8'(n), "R6 final address", v, st + 8'(n));
    reg_rd(2'd1, v); chk(v == 8'd0, "R6 final count", v, 0);
    reg_rd(2'd3, v); chk(v == 8'h04, "R7 enable cleared", v, 4);
    if (!dir)
      for (int i = 0; i < n; i++)
        chk(mem[8'(st + 8'(i))] == 8'hA0 + 8'(i), "R5 memory contents", mem[8'(st + 8'(i))], 8'hA0 + 8'(i));
  endtask

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; cs = 0; rd = 0; wr = 0; sel = 0; wdata = 0; force_gnt = 0;
    prev_req = 0; prev_irq = 0; exp_start = 0; exp_dir = 0;
    repeat (3) @(negedge clk);
    chk(!bus_req && !irq && !dev_ack && !mem_rd && !mem_wr && !mem_addr_oe && !mem_strb_oe,
        "R1 outputs in reset", {bus_req, irq, dev_ack, mem_rd, mem_wr}, 0);
    rst_n = 1'b1;
    reg_rd(2'd3, v); chk(v == 8'h04, "R1 status after reset", v, 4);

    // R2 register access
    reg_wr(2'd0, 8'h3C); reg_wr(2'd1, 8'h07); reg_wr(2'd2, 8'h02);
    reg_rd(2'd0, v); chk(v == 8'h3C, "R2 address readback", v, 8'h3C);
    reg_rd(2'd1, v); chk(v == 8'h07, "R2 count readback", v, 8'h07);
    reg_rd(2'd2, v); chk(v == 8'h02, "R2 control readback", v, 8'h02);
    reg_rd(2'd3, v); chk(v == 8'h00, "R2 status readback", v, 0);
    @(negedge clk); rd = 1'b1; sel = 2'd0; cs = 1'b0;
    #1 chk(rdata == 8'h00, "R2 read without select", rdata, 0);
    @(negedge clk); rd = 1'b0;

    // R3 writes ignored without select or during grant
    reg_wr(2'd0, 8'h99, 1'b0);
    reg_rd(2'd0, v); chk(v == 8'h3C, "R3 write without select", v, 8'h3C);
    @(negedge clk); force_gnt = 1'b1;
    reg_wr(2'd1, 8'h55);
    @(negedge clk); cs = 1'b1; rd = 1'b1; sel = 2'd1;
    #1 chk(rdata == 8'h00, "R2 read blocked during grant", rdata, 0);
    @(negedge clk); cs = 1'b0; rd = 1'b0; force_gnt = 1'b0;
    reg_rd(2'd1, v); chk(v == 8'h07, "R3 write during grant", v, 8'h07);

    // R10 disabled with a pending request
    @(negedge clk); pending = 1;
    repeat (5) @(negedge clk);
    chk(!bus_req, "R10 disabled request", bus_req, 0);
    // R10 enabled with zero count
    reg_wr(2'd1, 8'h00); reg_wr(2'd2, 8'h01);
    repeat (5) @(negedge clk);
    chk(!bus_req, "R10 zero count request", bus_req, 0);
    reg_wr(2'd2, 8'h00);
    @(negedge clk); pending = 0;

    // R4 request held off until grant
    reg_wr(2'd0, 8'h10); reg_wr(2'd1, 8'h01); reg_wr(2'd2, 8'h01);
    exp_start = 8'h10; exp_dir = 0; gd_cfg = 4; k = 0;
    @(negedge clk); pending = 1;
    @(negedge clk);
    chk(bus_req, "R4 request raised", bus_req, 1);
    repeat (3) @(negedge clk);
    chk(!mem_wr && !mem_rd && !dev_ack, "R4 no strobe before grant", mem_wr, 0);
    for (int t = 0; t < 40 && irqs == 0; t++) @(negedge clk);
    chk(irqs == 1, "R4 transfer after grant", irqs, 1);
    pending = 0;
    repeat (3) @(negedge clk);

    // sweep: direction, count, grant delay, peripheral hold-off
    for (int d = 0; d < 2; d++)
      for (int n = 1; n <= 4; n++)
        for (int g = 0; g < 3; g++)
          for (int h = 0; h < 2; h++)
            run_job(d[0], n, g, h, 8'(d * 37 + n * 11 + g * 5 + h * 3));
    // address wrap
    run_job(1'b0, 4, 1, 0, 8'hFE);
    run_job(1'b1, 3, 0, 1, 8'hFF);

    done_all = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_all) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule